// File: doc/BRIEF.md
# Flow-Through Word Memory with Contents Streaming

This block is a word-addressed storage array with a combinational read path and a clocked write port. Two control inputs select the operation of each cycle: with the enable low nothing happens and the output is held at zero; with the enable high, the write control chooses a read or a write. A read presents the selected word on the output in the same cycle, and the output follows any change of address without waiting for a clock edge. A write stores the input word on the rising clock edge. The output is zero during a write.

Alongside the access port, the block keeps a high-water mark: the highest word index written since the last reset. When a one-cycle dump request is sampled, the block streams every word from index zero up to that mark, one word per clock. Each word comes with its index and a valid strobe, and a done pulse follows the last word. This lets a test environment read out the contents a program has modified without any file access. The depth is a parameter. The full configuration holds 65536 sixteen-bit words, and a small depth is used for test. A build option zero-fills the storage on reset.

Top module: `fmem_dump`

## Requirements
- R1: The word index is the low log2(DEPTH) bits of the 16-bit address (DEPTH is a power of two). Higher address bits are ignored, so addresses that differ only above the index bits reach the same word.
- R2: With `memEn` low, no word is written whatever `memWr` is, and `rdData` is zero.
- R3: With `memEn` high and `memWr` low, `rdData` equals the word at the addressed index and follows an address change within the same cycle, with no clock edge involved.
- R4: With `memEn` and `memWr` high, `wrData` is stored at the addressed index on the rising clock edge, and `rdData` is zero during that cycle.
- R5: The high-water mark is the largest index written since reset. A later write to a lower index does not lower it.
- R6: A `dumpReq` sampled high at a rising edge while no dump runs, with at least one write since reset, starts a dump. Starting in the next cycle, `dumpValid` is high for one cycle per word. `dumpAddr` runs 0, 1, 2 and so on up to the high-water mark held at the request edge, and `dumpData` is the word currently stored at that index.
- R7: `dumpDone` is high for exactly one cycle, in the cycle after the last beat, and is never high together with `dumpValid`.
- R8: If nothing has been written since reset, a dump request produces no beats, and `dumpDone` is high in the cycle right after the request edge.
- R9: A `dumpReq` sampled while a dump is running is ignored. The running dump neither restarts nor lengthens.
- R10: Reads and writes keep working while a dump runs. A write that raises the high-water mark during a dump does not extend the dump that is already running.
- R11: `rst` is synchronous and active high. It clears the high-water mark, aborts a running dump (`dumpValid` and `dumpDone` are low after the reset edge), and blocks writes. With `CLEAR_ON_RST` set, it also zero-fills every word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and control state update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memEn | input | 1 | Access enable |
| memWr | input | 1 | Write select when enabled (1 = write, 0 = read) |
| addr | input | 16 | Word address |
| wrData | input | 16 | Word to store on a write |
| rdData | output | 16 | Read word, zero unless a read is active |
| dumpReq | input | 1 | One-cycle request to stream the written range |
| dumpValid | output | 1 | A dump beat is present |
| dumpAddr | output | 16 | Index of the current dump beat |
| dumpData | output | 16 | Word stored at `dumpAddr` |
| dumpDone | output | 1 | One-cycle pulse after the final beat or after an empty request |

## Verification
The hardest situation to reach from the ports is a dump that overlaps other traffic. This covers a second request, a read, a write beyond the current high-water mark, and a reset, each landing on a chosen beat of a running dump. The stimulus counts beats from the request edge and injects each event at a known beat index. It then checks that the address sequence neither restarts nor runs past the mark captured at the request. A reset landed mid-stream, followed by an immediate request, shows that both the mark and the written flag were cleared, because the request must then finish in one cycle with no beats.

// File: rtl/fmem_pkg.sv
package fmem_pkg;

  // Per-cycle strobes from the control path to the storage datapath.
  typedef struct packed {
    logic wrEn;    // store wrData at the addressed word this edge
    logic rdEn;    // drive the addressed word onto rdData
    logic clrAll;  // zero-fill storage (reset with clear option)
  } memStrobe_t;

  typedef enum logic {
    DUMP_IDLE = 1'b0,
    DUMP_RUN  = 1'b1
  } dumpState_t;

endpackage

// File: rtl/fmem_hwm.sv
module fmem_hwm #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output logic             anyWritten,
  output logic [IDX_W-1:0] highIdx
);

  logic raise;

  // A write raises the mark when it is the first one or lands above it.
  always_comb begin
    raise = wrEn && (!anyWritten || (wrIdx > highIdx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      anyWritten <= 1'b0;
      highIdx    <= '0;
    end else begin
      if (wrEn) begin
        anyWritten <= 1'b1;
      end
      if (raise) begin
        highIdx <= wrIdx;
      end
    end
  end

endmodule

// File: rtl/fmem_ctrl.sv
module fmem_ctrl
  import fmem_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             memEn,
  input  logic             memWr,
  input  logic [IDX_W-1:0] accIdx,
  input  logic             dumpReq,
  output memStrobe_t       strobe,
  output logic [IDX_W-1:0] dumpPtr,
  output logic             dumpValid,
  output logic             dumpDone
);

  dumpState_t       state;
  logic [IDX_W-1:0] lastIdx;
  logic             anyWritten;
  logic [IDX_W-1:0] highIdx;
  logic             doneReg;
  logic             atLast;

  // Access decode: writes are blocked while reset is held.
  always_comb begin
    strobe.rdEn   = memEn && !memWr;
    strobe.wrEn   = memEn && memWr && !rst;
    strobe.clrAll = rst;
  end

  fmem_hwm #(.IDX_W(IDX_W)) u_hwm (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (strobe.wrEn),
    .wrIdx      (accIdx),
    .anyWritten (anyWritten),
    .highIdx    (highIdx)
  );

  always_comb begin
    atLast = (dumpPtr == lastIdx);
  end

  // Dump sequencer: the limit is captured at the request edge, so writes
  // made while streaming do not stretch the running dump.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DUMP_IDLE;
      dumpPtr <= '0;
      lastIdx <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        DUMP_IDLE: begin
          if (dumpReq) begin
            if (anyWritten) begin
              state   <= DUMP_RUN;
              dumpPtr <= '0;
              lastIdx <= highIdx;
            end else begin
              doneReg <= 1'b1;
            end
          end
        end
        DUMP_RUN: begin
          if (atLast) begin
            state   <= DUMP_IDLE;
            doneReg <= 1'b1;
          end else begin
            dumpPtr <= dumpPtr + 1'b1;
          end
        end
        default: state <= DUMP_IDLE;
      endcase
    end
  end

  always_comb begin
    dumpValid = (state == DUMP_RUN);
    dumpDone  = doneReg;
  end

endmodule

// File: rtl/fmem_data.sv
module fmem_data
  import fmem_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 256,
  parameter bit CLEAR_ON_RST = 1'b1,
  localparam int IDX_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  memStrobe_t        strobe,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [IDX_W-1:0]  dumpPtr,
  output logic [DATA_W-1:0] dumpData
);

  logic [DATA_W-1:0] store [DEPTH];

  generate
    if (CLEAR_ON_RST) begin : g_clear
      always_ff @(posedge clk) begin
        if (strobe.clrAll) begin
          for (int i = 0; i < DEPTH; i++) begin
            store[i] <= '0;
          end
        end else if (strobe.wrEn) begin
          store[accIdx] <= wrData;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (strobe.wrEn) begin
          store[accIdx] <= wrData;
        end
      end
    end
  endgenerate

  // Flow-through read port and a second combinational port for the dump.
  always_comb begin
    rdData   = strobe.rdEn ? store[accIdx] : '0;
    dumpData = store[dumpPtr];
  end

endmodule

// File: rtl/fmem_dump.sv
module fmem_dump
  import fmem_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 256,
  parameter bit CLEAR_ON_RST = 1'b1,
  localparam int IDX_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              memEn,
  input  logic              memWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              dumpReq,
  output logic              dumpValid,
  output logic [ADDR_W-1:0] dumpAddr,
  output logic [DATA_W-1:0] dumpData,
  output logic              dumpDone
);

  memStrobe_t       strobe;
  logic [IDX_W-1:0] accIdx;
  logic [IDX_W-1:0] dumpPtr;

  // Upper address bits above the index are ignored (aliasing).
  always_comb begin
    accIdx   = addr[IDX_W-1:0];
    dumpAddr = ADDR_W'(dumpPtr);
  end

  fmem_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .memEn     (memEn),
    .memWr     (memWr),
    .accIdx    (accIdx),
    .dumpReq   (dumpReq),
    .strobe    (strobe),
    .dumpPtr   (dumpPtr),
    .dumpValid (dumpValid),
    .dumpDone  (dumpDone)
  );

  fmem_data #(
    .DATA_W       (DATA_W),
    .DEPTH        (DEPTH),
    .CLEAR_ON_RST (CLEAR_ON_RST)
  ) u_data (
    .clk      (clk),
    .strobe   (strobe),
    .accIdx   (accIdx),
    .wrData   (wrData),
    .rdData   (rdData),
    .dumpPtr  (dumpPtr),
    .dumpData (dumpData)
  );

endmodule

// File: rtl/fmem_chk.sv
module fmem_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              memEn,
  input logic              memWr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              dumpValid,
  input logic [ADDR_W-1:0] dumpAddr,
  input logic              dumpDone
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !memEn |-> (rdData == '0));

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (memEn && memWr) |-> (rdData == '0));

  // Write followed by a read of the same address returns the stored word.
  assert_wr_then_rd_R3: assert property (@(posedge clk) disable iff (rst)
    (memEn && !memWr && $past(memEn && memWr) && !$past(rst) && (addr == $past(addr)))
      |-> (rdData == $past(wrData)));

  assert_first_beat_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dumpValid) |-> (dumpAddr == '0));

  assert_beat_step_R6: assert property (@(posedge clk) disable iff (rst)
    (dumpValid && $past(dumpValid)) |-> (dumpAddr == ADDR_W'($past(dumpAddr) + 1'b1)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    dumpDone |=> !dumpDone);

  assert_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(dumpDone && dumpValid));

  assert_reset_abort_R11: assert property (@(posedge clk)
    rst |=> (!dumpValid && !dumpDone));

endmodule

bind fmem_dump fmem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .memEn     (memEn),
  .memWr     (memWr),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .dumpValid (dumpValid),
  .dumpAddr  (dumpAddr),
  .dumpDone  (dumpDone)
);

// File: tb/sim_fmem_dump.sv
`timescale 1ns/1ps
module sim_fmem_dump;

  localparam int DEPTH = 256;
  localparam int NVEC  = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memEn = 1'b0;
  logic        memWr = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        dumpReq = 1'b0;
  logic        dumpValid;
  logic [15:0] dumpAddr;
  logic [15:0] dumpData;
  logic        dumpDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;  // 125 MHz

  fmem_dump #(.DEPTH(DEPTH), .CLEAR_ON_RST(1'b1)) u0 (
    .clk(clk), .rst(rst), .memEn(memEn), .memWr(memWr), .addr(addr),
    .wrData(wrData), .rdData(rdData), .dumpReq(dumpReq),
    .dumpValid(dumpValid), .dumpAddr(dumpAddr), .dumpData(dumpData),
    .dumpDone(dumpDone)
  );

  // {memEn, memWr, addr, wrData, expected rdData}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 16'h0005, 16'hAAAA, 16'h0000},  // R2 disabled write
    {1'b1, 1'b0, 16'h0005, 16'h0000, 16'h0000},  // R2 nothing stored
    {1'b1, 1'b1, 16'h0005, 16'h1234, 16'h0000},  // R4
    {1'b1, 1'b0, 16'h0005, 16'h0000, 16'h1234},  // R3
    {1'b1, 1'b1, 16'h0010, 16'hBEEF, 16'h0000},  // R4
    {1'b0, 1'b0, 16'h0010, 16'h0000, 16'h0000},  // R2
    {1'b1, 1'b0, 16'h0010, 16'h0000, 16'hBEEF},  // R3
    {1'b1, 1'b0, 16'h0110, 16'h0000, 16'hBEEF},  // R1 alias
    {1'b1, 1'b1, 16'h0103, 16'h0F0F, 16'h0000},  // R1 alias write
    {1'b1, 1'b0, 16'h0003, 16'h0000, 16'h0F0F},  // R1
    {1'b1, 1'b0, 16'h0004, 16'h0000, 16'h0000}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_bus();
    memEn = 1'b0; memWr = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    memEn = 1'b1; memWr = 1'b1; addr = a; wrData = d;
    model[a[7:0]] = d;
    step();
    idle_bus();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  // Full dump with no interference; expects beats 0..last.
  task automatic run_dump(input int last, input string req);
    dumpReq = 1'b1;
    step();
    dumpReq = 1'b0;
    for (int i = 0; i <= last; i++) begin
      check({req, " valid"}, 32'(dumpValid), 32'd1);
      check({req, " addr"}, 32'(dumpAddr), 32'(i));
      check({req, " data"}, 32'(dumpData), 32'(model[i]));
      step();
    end
    check("R7 done after last beat", 32'(dumpDone), 32'd1);
    check("R7 valid low at done", 32'(dumpValid), 32'd0);
    step();
    check("R7 done single cycle", 32'(dumpDone), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    step();
    step();
    rst = 1'b0;
    #1;
    check("R11 reset dumpValid", 32'(dumpValid), 32'd0);
    check("R11 reset dumpDone", 32'(dumpDone), 32'd0);
    check("R2 reset rdData", 32'(rdData), 32'd0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      memEn  = VEC[v][49];
      memWr  = VEC[v][48];
      addr   = VEC[v][47:32];
      wrData = VEC[v][31:16];
      #1;
      check($sformatf("R1-table vector %0d rdData", v), 32'(rdData), 32'(VEC[v][15:0]));
      if (memEn && memWr) model[addr[7:0]] = wrData;
      step();
    end
    idle_bus();

    // R3: combinational follow within one cycle
    memEn = 1'b1; memWr = 1'b0; addr = 16'h0005;
    #1;
    check("R3 flow-through first addr", 32'(rdData), 32'h1234);
    addr = 16'h0003;
    #1;
    check("R3 flow-through changed addr", 32'(rdData), 32'h0F0F);
    idle_bus();
    step();

    // R6/R7: dump up to index 0x10
    run_dump(16, "R6 dump");

    // R5: lower write does not lower the mark; R9/R10 interference
    do_write(16'h0002, 16'h2222);
    dumpReq = 1'b1;
    step();
    dumpReq = 1'b0;
    for (int i = 0; i <= 16; i++) begin
      check("R9 beat addr", 32'(dumpAddr), 32'(i));
      check("R5 beat valid", 32'(dumpValid), 32'd1);
      if (i == 2) check("R10 beat data", 32'(dumpData), 32'h2222);
      if (i == 3) dumpReq = 1'b1;          // R9 second request ignored
      if (i == 5) begin                     // R10 read during dump
        memEn = 1'b1; memWr = 1'b0; addr = 16'h0005;
        #1;
        check("R10 read during dump", 32'(rdData), 32'h1234);
      end
      if (i == 6) begin                     // R10 write above the mark
        memEn = 1'b1; memWr = 1'b1; addr = 16'h0030; wrData = 16'h7777;
        model[8'h30] = 16'h7777;
      end
      step();
      dumpReq = 1'b0;
      idle_bus();
    end
    check("R10 dump not extended", 32'(dumpValid), 32'd0);
    check("R7 done after interfered dump", 32'(dumpDone), 32'd1);
    step();
    memEn = 1'b1; memWr = 1'b0; addr = 16'h0030;
    #1;
    check("R10 write during dump stored", 32'(rdData), 32'h7777);
    idle_bus();

    // Next dump reaches the raised mark 0x30
    run_dump(48, "R5 raised mark");

    // R11: reset mid-dump with a write attempt during reset
    dumpReq = 1'b1;
    step();
    dumpReq = 1'b0;
    step();
    step();
    rst = 1'b1; memEn = 1'b1; memWr = 1'b1; addr = 16'h0007; wrData = 16'h5555;
    step();
    rst = 1'b0;
    idle_bus();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    check("R11 dump aborted", 32'(dumpValid), 32'd0);
    check("R11 no done after abort", 32'(dumpDone), 32'd0);
    memEn = 1'b1; memWr = 1'b0; addr = 16'h0007;
    #1;
    check("R11 write during reset blocked", 32'(rdData), 32'h0000);
    addr = 16'h0005;
    #1;
    check("R11 storage cleared", 32'(rdData), 32'h0000);
    idle_bus();
    step();

    // R8: empty dump after reset
    dumpReq = 1'b1;
    step();
    dumpReq = 1'b0;
    check("R8 empty dump done", 32'(dumpDone), 32'd1);
    check("R8 empty dump no beat", 32'(dumpValid), 32'd0);
    step();
    check("R8 done single cycle", 32'(dumpDone), 32'd0);
    check("R8 still no beat", 32'(dumpValid), 32'd0);

    // R5: high then low write, dump covers 0..8
    do_write(16'h0008, 16'h8888);
    do_write(16'h0002, 16'h0202);
    run_dump(8, "R5 mark kept");

    // R2: disabled write leaves a dumped word unchanged
    memEn = 1'b0; memWr = 1'b1; addr = 16'h0008; wrData = 16'hDEAD;
    step();
    idle_bus();
    memEn = 1'b1; addr = 16'h0008;
    #1;
    check("R2 disabled write ignored", 32'(rdData), 32'h8888);
    idle_bus();
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule